// File: doc/BRIEF.md
# Device Lifecycle State Controller

This block holds the security lifecycle state of a device and decides whether requests to change that state are allowed. There are six states, ordered from least to most secure. Moving forward to a more secure state is normally free. Moving backward out of the Closed state needs a validated authorization certificate. The Locked state can never be left. The block also decides, per state, whether debug access is allowed in the secure domain and in the nonsecure domain. In the Closed state a certificate can open a temporary debug session.

Certificate checking, non-volatile storage and root-of-trust code are outside the block. The certificate result arrives as one validated bit. The persisted state is presented on `storedState` and copied in while reset is held. Every request gets a one-cycle reply pulse on the cycle after it is made. An accepted transition updates `lcState` on the same edge that raises the accept pulse.

Top module: `lifecycle_ctrl`

## Requirements
- R1: `lcState` carries a 3-bit code that rises with security: Open=0, Provisioning=1, RoT-Provisioned=2, TZ-Closed=3, Closed=4, Locked=5. The codes 6 and 7 never appear on it.
- R2: While `rstN` is low at a clock edge, the state is loaded from `storedState`, and codes 6 and 7 load as Locked (5). All reply pulses are cleared and any debug session ends.
- R3: A request (`transReq` high) to a valid higher code is accepted without a certificate from Open, RoT-Provisioned, TZ-Closed and Closed. Exactly one of `transAck` or `transNack` is high for one cycle on the cycle after the request. On an accept, `lcState` shows the target in that same cycle.
- R4: A request whose target equals the current state is rejected and also raises `transNoop`. A request with target code 6 or 7 is rejected.
- R5: From Provisioning, a move to any higher code is accepted only if `provDone` is high in the request cycle. A move back to Open is accepted.
- R6: From Closed, a move to a lower code is accepted only if `certValid` is high in the request cycle, and is rejected otherwise. From Provisioning, RoT-Provisioned and TZ-Closed, moves to lower codes are accepted without a certificate.
- R7: In Locked, every transition request and every debug request is rejected, and the state stays Locked.
- R8: Without a session, `dbgEnSec` is high only in Open. `dbgEnNs` is high in Open, Provisioning, RoT-Provisioned and TZ-Closed. Both are low in Closed and Locked.
- R9: A debug request (`dbgReq` high, `dbgSecure` = 1 for the secure domain and 0 for nonsecure) gets `dbgAck` on the next cycle if that domain's enable is high. Otherwise it gets `dbgNack`.
- R10: In Closed, a debug request made with `certValid` high is acknowledged and starts a session. During the session both enables are high from the next cycle. A `sessionEnd` pulse ends the session, with the enables falling in the following cycle.
- R11: An accepted transition ends any session. A `sessionEnd` in the same cycle as a session-opening request takes priority, so no session starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; loads the stored state |
| storedState | input | 3 | Persisted lifecycle code, read while reset is held |
| transReq | input | 1 | Transition request strobe |
| transTarget | input | 3 | Requested target state code |
| certValid | input | 1 | A validated authorization certificate accompanies this cycle's request |
| provDone | input | 1 | Root-of-trust installation has completed |
| dbgReq | input | 1 | Debug access request strobe |
| dbgSecure | input | 1 | Domain of the debug request: 1 secure, 0 nonsecure |
| sessionEnd | input | 1 | Ends an open debug session |
| lcState | output | 3 | Current lifecycle state code |
| transAck | output | 1 | Transition accepted (one-cycle pulse) |
| transNack | output | 1 | Transition rejected (one-cycle pulse) |
| transNoop | output | 1 | Rejected request targeted the current state |
| dbgAck | output | 1 | Debug request granted (one-cycle pulse) |
| dbgNack | output | 1 | Debug request refused (one-cycle pulse) |
| dbgEnNs | output | 1 | Debug enabled in the nonsecure domain |
| dbgEnSec | output | 1 | Debug enabled in the secure domain |

## Verification
The hardest case to reach is a certificate debug session in Closed that meets another event on the same edge: an accepted transition, a `sessionEnd`, or a second request. Random transitions drift toward Locked and seldom stay in Closed. To counter this, the bench resets often with a random `storedState`, which puts the block directly into Closed (and into the invalid codes). It also drives certificate, session-end and debug strobes at high rates. Directed sequences cover each collision on purpose.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    LC_OPEN   = 3'd0,
    LC_PROV   = 3'd1,
    LC_ROTP   = 3'd2,
    LC_TZCL   = 3'd3,
    LC_CLOSED = 3'd4,
    LC_LOCKED = 3'd5
  } lcState_e;

  // Decisions handed from control to datapath for one clock edge.
  typedef struct packed {
    logic     stateLoad;
    lcState_e nextState;
    logic     transAck;
    logic     transNack;
    logic     transNoop;
    logic     dbgAck;
    logic     dbgNack;
    logic     sessOpen;
    logic     sessClose;
  } lcStrobe_t;

  // Unused codes fail safe into the terminal state.
  function automatic lcState_e sanitize(input logic [STATE_W-1:0] code);
    if (code > STATE_W'(LC_LOCKED)) return LC_LOCKED;
    return lcState_e'(code);
  endfunction

endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
(
  input  lcState_e           curState,
  input  logic               sessActive,
  input  logic               enNs,
  input  logic               enSec,
  input  logic               transReq,
  input  logic [STATE_W-1:0] transTarget,
  input  logic               certValid,
  input  logic               provDone,
  input  logic               dbgReq,
  input  logic               dbgSecure,
  input  logic               sessionEnd,
  output lcStrobe_t          strobe
);

  logic tgtValid;
  logic isSame;
  logic goForward;
  logic transAllow;
  logic domainOpen;
  logic certDebug;

  // Transition policy
  always_comb begin
    tgtValid   = transTarget <= STATE_W'(LC_LOCKED);
    isSame     = transTarget == STATE_W'(curState);
    goForward  = transTarget > STATE_W'(curState);
    transAllow = 1'b0;
    if (curState != LC_LOCKED && tgtValid && !isSame) begin
      if (goForward) begin
        // Root of trust must be installed before leaving provisioning upward
        transAllow = (curState == LC_PROV) ? provDone : 1'b1;
      end else begin
        // Regression from Closed needs a certificate
        transAllow = (curState == LC_CLOSED) ? certValid : 1'b1;
      end
    end
  end

  // Debug policy
  always_comb begin
    domainOpen = dbgSecure ? enSec : enNs;
    certDebug  = (curState == LC_CLOSED) && certValid;
  end

  always_comb begin
    strobe           = '0;
    strobe.nextState = curState;
    if (transReq) begin
      strobe.transAck  = transAllow;
      strobe.transNack = !transAllow;
      strobe.transNoop = isSame;
      if (transAllow) begin
        strobe.stateLoad = 1'b1;
        strobe.nextState = lcState_e'(transTarget);
      end
    end
    if (dbgReq) begin
      strobe.dbgAck   = domainOpen || certDebug;
      strobe.dbgNack  = !(domainOpen || certDebug);
      strobe.sessOpen = certDebug && !sessActive;
    end
    strobe.sessClose = sessionEnd || strobe.stateLoad;
  end

endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] storedState,
  input  lcStrobe_t          strobe,
  input  logic               dbgReqIn,
  output lcState_e           curState,
  output logic               sessActive,
  output logic               enNs,
  output logic               enSec,
  output logic               transAck,
  output logic               transNack,
  output logic               transNoop,
  output logic               dbgAck,
  output logic               dbgNack
);

  lcState_e stateQ;
  logic     sessQ;
  logic     armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= sanitize(storedState);
      sessQ     <= 1'b0;
      armed     <= 1'b0;
      transAck  <= 1'b0;
      transNack <= 1'b0;
      transNoop <= 1'b0;
      dbgAck    <= 1'b0;
      dbgNack   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (strobe.stateLoad) stateQ <= strobe.nextState;
      if (strobe.sessClose)      sessQ <= 1'b0;
      else if (strobe.sessOpen)  sessQ <= 1'b1;
      transAck  <= strobe.transAck;
      transNack <= strobe.transNack;
      transNoop <= strobe.transNoop;
      dbgAck    <= strobe.dbgAck;
      dbgNack   <= strobe.dbgNack;
    end
  end

  assign curState   = stateQ;
  assign sessActive = sessQ;
  assign enNs  = (stateQ <= LC_TZCL) || sessQ;
  assign enSec = (stateQ == LC_OPEN) || sessQ;

  // R1: only defined codes are held
  assert_valid_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    stateQ <= LC_LOCKED);

  // R3: the state moves only with an accept pulse
  assert_move_needs_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && stateQ != $past(stateQ)) |-> transAck);

  // R3: accept and reject never together
  assert_reply_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({transAck, transNack}));

  // R4: a no-op is always a rejection
  assert_noop_is_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    transNoop |-> transNack);

  // R7: Locked is terminal
  assert_locked_terminal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == LC_LOCKED) |=> (stateQ == LC_LOCKED));

  // R7: debug refused in Locked
  assert_locked_no_debug_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == LC_LOCKED && dbgReqIn) |=> dbgNack);

  // R9: a debug reply always follows a request
  assert_dbg_reply_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dbgAck || dbgNack) |-> (armed && $past(dbgReqIn)));

  // R10: sessions exist only in Closed
  assert_session_closed_R10: assert property (@(posedge clk) disable iff (!rstN)
    sessQ |-> (stateQ == LC_CLOSED));

endmodule

// File: rtl/lifecycle_ctrl.sv
module lifecycle_ctrl
  import lc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] storedState,
  input  logic               transReq,
  input  logic [STATE_W-1:0] transTarget,
  input  logic               certValid,
  input  logic               provDone,
  input  logic               dbgReq,
  input  logic               dbgSecure,
  input  logic               sessionEnd,
  output logic [STATE_W-1:0] lcState,
  output logic               transAck,
  output logic               transNack,
  output logic               transNoop,
  output logic               dbgAck,
  output logic               dbgNack,
  output logic               dbgEnNs,
  output logic               dbgEnSec
);

  lcStrobe_t strobe;
  lcState_e  curState;
  logic      sessActive;
  logic      enNs;
  logic      enSec;

  lc_ctrl u_ctrl (
    .curState    (curState),
    .sessActive  (sessActive),
    .enNs        (enNs),
    .enSec       (enSec),
    .transReq    (transReq),
    .transTarget (transTarget),
    .certValid   (certValid),
    .provDone    (provDone),
    .dbgReq      (dbgReq),
    .dbgSecure   (dbgSecure),
    .sessionEnd  (sessionEnd),
    .strobe      (strobe)
  );

  lc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .storedState (storedState),
    .strobe      (strobe),
    .dbgReqIn    (dbgReq),
    .curState    (curState),
    .sessActive  (sessActive),
    .enNs        (enNs),
    .enSec       (enSec),
    .transAck    (transAck),
    .transNack   (transNack),
    .transNoop   (transNoop),
    .dbgAck      (dbgAck),
    .dbgNack     (dbgNack)
  );

  assign lcState  = curState;
  assign dbgEnNs  = enNs;
  assign dbgEnSec = enSec;

endmodule

// File: tb/lifecycle_ctrl_tb.sv
`timescale 1ns/1ps
module lifecycle_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] storedState = 3'd0;
  logic       transReq = 1'b0;
  logic [2:0] transTarget = 3'd0;
  logic       certValid = 1'b0;
  logic       provDone = 1'b0;
  logic       dbgReq = 1'b0;
  logic       dbgSecure = 1'b0;
  logic       sessionEnd = 1'b0;
  logic [2:0] lcState;
  logic       transAck, transNack, transNoop, dbgAck, dbgNack, dbgEnNs, dbgEnSec;

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] mState = 3'd0;
  logic       mSess = 1'b0;

  always #2 clk = ~clk;

  lifecycle_ctrl u_dut (
    .clk(clk), .rstN(rstN), .storedState(storedState),
    .transReq(transReq), .transTarget(transTarget), .certValid(certValid),
    .provDone(provDone), .dbgReq(dbgReq), .dbgSecure(dbgSecure),
    .sessionEnd(sessionEnd), .lcState(lcState), .transAck(transAck),
    .transNack(transNack), .transNoop(transNoop), .dbgAck(dbgAck),
    .dbgNack(dbgNack), .dbgEnNs(dbgEnNs), .dbgEnSec(dbgEnSec)
  );

  function automatic logic [2:0] sanit(input logic [2:0] s);
    return (s > 3'd5) ? 3'd5 : s;
  endfunction

  function automatic logic transOk(input logic [2:0] cur, input logic [2:0] tg,
                                   input logic cv, input logic pd);
    if (cur == 3'd5 || tg > 3'd5 || tg == cur) return 1'b0;
    if (tg > cur) return (cur == 3'd1) ? pd : 1'b1;
    return (cur == 3'd4) ? cv : 1'b1;
  endfunction

  function automatic logic expNs(input logic [2:0] s, input logic ss);
    return (s <= 3'd3) || ss;
  endfunction

  function automatic logic expSec(input logic [2:0] s, input logic ss);
    return (s == 3'd0) || ss;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [2:0] act, input logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkLevels(input string tag);
    chk("R1", "lcState", lcState, mState);
    chk(tag, "dbgEnNs", {2'b0, dbgEnNs}, {2'b0, expNs(mState, mSess)});
    chk(tag, "dbgEnSec", {2'b0, dbgEnSec}, {2'b0, expSec(mState, mSess)});
  endtask

  // R2: reset loads stored code, invalid codes become Locked
  task automatic doReset(input logic [2:0] s);
    rstN = 1'b0; storedState = s; transReq = 0; dbgReq = 0; sessionEnd = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    mState = sanit(s); mSess = 1'b0;
    chk("R2", "reset state", lcState, sanit(s));
    chk("R2", "reset pulses", {transAck, transNack, dbgAck}, 3'd0);
    chk("R2", "reset dbgNack", {2'b0, dbgNack}, 3'd0);
    checkLevels("R8");
  endtask

  task automatic step(input logic tr, input logic [2:0] tg, input logic cv,
                      input logic pd, input logic dr, input logic ds,
                      input logic se, input string tT, input string tD);
    logic [2:0] pre;
    logic preS, ok, dOk;
    transReq = tr; transTarget = tg; certValid = cv; provDone = pd;
    dbgReq = dr; dbgSecure = ds; sessionEnd = se;
    @(negedge clk);
    pre = mState; preS = mSess;
    ok  = tr && transOk(pre, tg, cv, pd);
    dOk = dr && ((ds ? expSec(pre, preS) : expNs(pre, preS)) || (pre == 3'd4 && cv));
    if (ok) mState = tg;
    if (ok || se) mSess = 1'b0;
    else if (dr && pre == 3'd4 && cv) mSess = 1'b1;
    chk(tT, "transAck", {2'b0, transAck}, {2'b0, ok});
    chk(tT, "transNack", {2'b0, transNack}, {2'b0, tr && !ok});
    chk("R4", "transNoop", {2'b0, transNoop}, {2'b0, tr && tg == pre});
    chk(tD, "dbgAck", {2'b0, dbgAck}, {2'b0, dOk});
    chk(tD, "dbgNack", {2'b0, dbgNack}, {2'b0, dr && !dOk});
    checkLevels(tD == "R10" || tD == "R11" ? tD : "R8");
    transReq = 0; dbgReq = 0; sessionEnd = 0;
  endtask

  function automatic string tagFor(input logic [2:0] cur, input logic [2:0] tg);
    if (cur == 3'd5) return "R7";
    if (tg == cur || tg > 3'd5) return "R4";
    if (cur == 3'd1) return "R5";
    if (tg < cur) return "R6";
    return "R3";
  endfunction

  initial begin : watchdog
    #(4ns * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1c5eed));
    @(negedge clk);
    doReset(3'd0);                                      // R2 Open, R8 both enabled
    step(0, 0, 0, 0, 1, 1, 0, "R3", "R9");              // R9 secure debug in Open
    doReset(3'd7);                                      // R2 invalid -> Locked
    doReset(3'd6);
    step(1, 3'd0, 1, 1, 1, 0, 0, "R7", "R7");           // R7 all rejected
    step(1, 3'd5, 1, 1, 0, 0, 0, "R7", "R7");
    doReset(3'd1);
    step(1, 3'd2, 0, 0, 0, 0, 0, "R5", "R9");           // R5 needs provDone
    step(1, 3'd4, 0, 0, 0, 0, 0, "R5", "R9");
    step(1, 3'd2, 0, 1, 0, 0, 0, "R5", "R9");
    step(1, 3'd2, 0, 0, 0, 0, 0, "R4", "R9");           // R4 same target
    step(1, 3'd6, 0, 0, 0, 0, 0, "R4", "R9");           // R4 invalid target
    step(1, 3'd3, 0, 0, 1, 1, 0, "R3", "R9");           // R3 forward; R9 secure refused
    step(0, 0, 0, 0, 1, 0, 0, "R3", "R9");              // R9 nonsecure granted
    step(1, 3'd4, 0, 0, 0, 0, 0, "R3", "R9");
    step(1, 3'd0, 0, 0, 1, 0, 0, "R6", "R9");           // R6 no cert
    step(1, 3'd1, 1, 0, 0, 0, 0, "R6", "R9");           // R6 with cert
    step(1, 3'd0, 0, 0, 0, 0, 0, "R5", "R9");           // R5 back to Open allowed
    doReset(3'd4);
    step(0, 0, 0, 0, 1, 1, 0, "R3", "R10");             // R10 no cert refused
    step(0, 0, 1, 0, 1, 1, 0, "R3", "R10");             // R10 session opens
    step(0, 0, 0, 0, 1, 1, 0, "R3", "R10");             // R10 session grants
    step(0, 0, 0, 0, 0, 0, 1, "R3", "R10");             // R10 session ends
    step(0, 0, 1, 0, 1, 0, 0, "R3", "R10");
    step(1, 3'd5, 0, 0, 0, 0, 0, "R3", "R11");          // R11 transition ends session
    doReset(3'd4);
    step(0, 0, 1, 0, 1, 0, 1, "R3", "R11");             // R11 end wins over open
    step(1, 3'd2, 1, 0, 1, 1, 0, "R6", "R11");          // R11 open vs accepted move
    for (int i = 0; i < 6000; i++) begin
      if (i % 37 == 0) doReset(3'($urandom % 8));
      else begin
        logic [2:0] tg;
        logic dr, cv;
        tg = 3'($urandom % 8);
        dr = ($urandom % 3) == 0;
        cv = $urandom % 2;
        step(($urandom % 3) == 0, tg, cv, 1'($urandom % 2), dr,
             1'($urandom % 2), ($urandom % 6) == 0, tagFor(mState, tg),
             (mState == 3'd4 || mSess) ? "R10" : "R9");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule